// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns a single asynchronous serial line into a stream of received characters. A sample enable, pulsed at sixteen times the bit rate, paces all work. The line rests high. After a two-flop synchroniser, a high-to-low change seen on a sample tick marks a possible start bit. The receiver re-checks the line at the centre of that bit, then takes each following bit at its centre. Data arrives least significant bit first.

Three runtime inputs set the character format: 7 or 8 data bits, no/even/odd parity, and one or two stop bits. They are captured when a start bit is detected. Each finished character is written, together with its parity-error and framing-error flags, into a 128-entry FIFO. The host drains the FIFO through a valid/ready read port while reception goes on. A character that arrives while the FIFO is full is discarded and raises a sticky overrun flag. The host clears that flag with a one-cycle strobe.

Top module: `async_rx`

## Requirements
- R1: After reset, `rd_valid_o` is 0, `count_o` is 0 and `overrun_o` is 0.
- R2: With `len8_i`=1 and `par_mode_i`=00 (no parity), a frame is received correctly when it holds one low start bit, 8 data bits least significant first, and a high stop bit. The FIFO then presents the data with both error flags clear.
- R3: With `len8_i`=0, only 7 data bits are taken. Bit 7 of the stored data reads 0, and the next bit on the line is treated as parity or stop.
- R4: With `par_mode_i`=01 (even), a parity bit is expected after the data. A frame whose data ones plus parity bit give an odd total is stored with `rd_perr_o`=1. A correct frame is stored with `rd_perr_o`=0.
- R5: With `par_mode_i`=10 (odd), the data ones plus parity bit must give an odd total, or else `rd_perr_o`=1. The code 11 behaves as no parity.
- R6: A stop bit sampled low stores the character with `rd_ferr_o`=1. With `stop2_i`=1, both stop bits are sampled, and a low second stop bit alone also sets `rd_ferr_o`.
- R7: A low pulse shorter than half a bit, which is high again by the centre of the start bit, stores no character.
- R8: The FIFO holds up to 128 characters and returns them in arrival order. `count_o` gives its occupancy. `rd_valid_o` is high exactly when `count_o` is nonzero. Each cycle with `rd_valid_o` and `rd_ready_i` both high removes one entry. While `rd_ready_i` is low, the head entry holds steady.
- R9: A character completed while the FIFO is full is dropped and sets `overrun_o`. The flag stays set until a cycle with `ovr_clr_i`=1; it clears on the next cycle unless a new overrun occurs in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable at 16x the bit rate |
| rxd_i | input | 1 | Serial input, idle high |
| len8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_mode_i | input | 2 | 00/11 none, 01 even, 10 odd |
| stop2_i | input | 1 | 1: two stop bits, 0: one |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rd_data_o | output | 8 | Data of the head character |
| rd_perr_o | output | 1 | Parity error of the head character |
| rd_ferr_o | output | 1 | Framing error of the head character |
| rd_valid_o | output | 1 | FIFO holds at least one character |
| rd_ready_i | input | 1 | Host takes the head character |
| count_o | output | CNT_W | FIFO occupancy |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The assertions on occupancy and the read port assume that `rd_ready_i` only matters while `rd_valid_o` is high. They also assume that the format inputs stay fixed for the length of each frame, since the format is captured at the start bit. The bench changes format only between frames, while the line is idle. It drives every bit for exactly sixteen sample ticks, with ticks on every second clock. It pulses the read and clear strobes for one cycle each, away from the clock edge. This keeps each bit centre well inside the driven bit, so the synchroniser delay never moves a sample into a neighbouring bit.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00, PAR_EVEN = 2'b01, PAR_ODD = 2'b10, PAR_NONE2 = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } rx_char_t;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
  import async_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rxd_i,
  input  logic     len8_i,
  input  logic [1:0] par_mode_i,
  input  logic     stop2_i,
  output logic     push_o,
  output rx_char_t char_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OSR / 2 - 1);

  rx_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]  idx_q;
  logic [7:0]  sh_q;
  logic        prev_q, acc_q, perr_q, ferr_q, stop_idx_q;
  logic        len8_q, stop2_q;
  par_mode_e   par_q;
  logic        par_en, last_bit, at_end;

  assign par_en   = (par_q == PAR_EVEN) || (par_q == PAR_ODD);
  assign last_bit = (idx_q == (len8_q ? 3'd7 : 3'd6));
  assign at_end   = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      sh_q       <= '0;
      prev_q     <= 1'b1;
      acc_q      <= 1'b0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      stop_idx_q <= 1'b0;
      len8_q     <= 1'b1;
      stop2_q    <= 1'b0;
      par_q      <= PAR_NONE;
      push_o     <= 1'b0;
      char_o     <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        prev_q <= rxd_i;
        case (state_q)
          ST_IDLE: if (prev_q && !rxd_i) begin
            state_q    <= ST_START;
            cnt_q      <= CW'(1);  // detection tick is tick 1 of the start bit
            len8_q     <= len8_i;
            stop2_q    <= stop2_i;
            par_q      <= par_mode_e'(par_mode_i);
            acc_q      <= 1'b0;
            perr_q     <= 1'b0;
            ferr_q     <= 1'b0;
            stop_idx_q <= 1'b0;
          end
          ST_START: if (cnt_q == CNT_MID) begin
            cnt_q <= '0;
            idx_q <= '0;
            state_q <= rxd_i ? ST_IDLE : ST_DATA;  // high at centre: glitch
          end else cnt_q <= cnt_q + 1'b1;
          ST_DATA: if (at_end) begin
            cnt_q <= '0;
            sh_q  <= {rxd_i, sh_q[7:1]};
            acc_q <= acc_q ^ rxd_i;
            idx_q <= idx_q + 1'b1;
            if (last_bit) state_q <= par_en ? ST_PAR : ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          ST_PAR: if (at_end) begin
            cnt_q   <= '0;
            perr_q  <= acc_q ^ rxd_i ^ (par_q == PAR_ODD);
            state_q <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          ST_STOP: if (at_end) begin
            cnt_q <= '0;
            if (stop2_q && !stop_idx_q) begin
              stop_idx_q <= 1'b1;
              ferr_q     <= ferr_q | ~rxd_i;
            end else begin
              state_q     <= ST_IDLE;
              push_o      <= 1'b1;
              char_o.data <= len8_q ? sh_q : {1'b0, sh_q[7:1]};
              char_o.perr <= perr_q;
              char_o.ferr <= ferr_q | ~rxd_i;
            end
          end else cnt_q <= cnt_q + 1'b1;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
  import async_rx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  rx_char_t         wdata_i,
  output logic             full_o,
  output rx_char_t         rdata_o,
  output logic             rvalid_o,
  input  logic             rready_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int AW = $clog2(DEPTH);

  rx_char_t mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en, rd_en;

  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign rvalid_o = (cnt_q != '0);
  assign wr_en    = push_i && !full_o;
  assign rd_en    = rvalid_o && rready_i;
  assign rdata_o  = mem_q[rp_q];
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i)
    if (wr_en) mem_q[wp_q] <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (rd_en) rp_q <= rp_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DEPTH       = 128,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rxd_i,
  input  logic             len8_i,
  input  logic [1:0]       par_mode_i,
  input  logic             stop2_i,
  input  logic             ovr_clr_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_perr_o,
  output logic             rd_ferr_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [CNT_W-1:0] count_o,
  output logic             overrun_o
);
  logic     rxd_s, frm_push, fifo_full;
  rx_char_t frm_char, head;

  async_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  async_rx_frame #(.OSR(OSR)) i_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_s),
    .len8_i(len8_i), .par_mode_i(par_mode_i), .stop2_i(stop2_i),
    .push_o(frm_push), .char_o(frm_char)
  );

  async_rx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(frm_push), .wdata_i(frm_char),
    .full_o(fifo_full), .rdata_o(head), .rvalid_o(rd_valid_o),
    .rready_i(rd_ready_i), .count_o(count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    overrun_o <= 1'b0;
    else if (frm_push && fifo_full) overrun_o <= 1'b1;
    else if (ovr_clr_i)             overrun_o <= 1'b0;

  assign rd_data_o = head.data;
  assign rd_perr_o = head.perr;
  assign rd_ferr_o = head.ferr;
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             full_i,
  input logic             ovr_clr_i,
  input logic             overrun_i,
  input logic             rd_valid_i,
  input logic             rd_ready_i,
  input logic [9:0]       head_i,
  input logic [CNT_W-1:0] count_i
);
  a_r8_valid_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i == (count_i != '0));

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));

  a_r8_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_i && !push_i) |=> count_i == $past(count_i) - 1'b1);

  a_r8_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_i && !(rd_valid_i && rd_ready_i)) |=> count_i == $past(count_i) + 1'b1);

  a_r8_head_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !rd_ready_i) |=> rd_valid_i && $stable(head_i));

  a_r9_overrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_i) |=> overrun_i);

  a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i && !ovr_clr_i) |=> overrun_i);

  a_r9_overrun_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_clr_i && !(push_i && full_i)) |=> !overrun_i);
endmodule

bind async_rx async_rx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .push_i(frm_push), .full_i(fifo_full),
  .ovr_clr_i(ovr_clr_i), .overrun_i(overrun_o), .rd_valid_i(rd_valid_o),
  .rd_ready_i(rd_ready_i), .head_i(head), .count_i(count_o)
);

// File: tb/test_async_rx.sv
module test_async_rx;
  localparam int BIT_CLK = 32;  // 16 ticks, one tick every 2 clocks
  localparam int DEPTH   = 128;

  typedef struct packed {
    logic       len8;
    logic [1:0] par;
    logic       stop2;
    logic [7:0] data;
    logic       bad_par;
    logic       bad_stop;
    logic [7:0] exp_data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b00, 1'b0, 8'hA5, 1'b0, 1'b0, 8'hA5},  // R2
    '{1'b1, 2'b00, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C},  // R2
    '{1'b0, 2'b00, 1'b0, 8'hD3, 1'b0, 1'b0, 8'h53},  // R3
    '{1'b1, 2'b01, 1'b0, 8'h96, 1'b0, 1'b0, 8'h96},  // R4
    '{1'b1, 2'b01, 1'b0, 8'h96, 1'b1, 1'b0, 8'h96},  // R4
    '{1'b1, 2'b10, 1'b1, 8'h01, 1'b0, 1'b0, 8'h01},  // R5
    '{1'b1, 2'b10, 1'b0, 8'h7F, 1'b1, 1'b0, 8'h7F},  // R5
    '{1'b1, 2'b00, 1'b0, 8'h55, 1'b0, 1'b1, 8'h55},  // R6
    '{1'b0, 2'b01, 1'b1, 8'h2A, 1'b0, 1'b1, 8'h2A}   // R6 second stop low
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       rxd = 1'b1;
  logic       len8 = 1'b1;
  logic [1:0] par = 2'b00;
  logic       stop2 = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_valid, overrun;
  logic [7:0] count;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;

  async_rx i_async_rx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .len8_i(len8), .par_mode_i(par), .stop2_i(stop2), .ovr_clr_i(ovr_clr),
    .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .count_o(count),
    .overrun_o(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send_frame(input vec_t v);
    int   nb = v.len8 ? 8 : 7;
    logic ones = 1'b0;
    len8 = v.len8; par = v.par; stop2 = v.stop2;
    send_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      send_bit(v.data[i]);
      ones ^= v.data[i];
    end
    if (v.par == 2'b01) send_bit(ones ^ v.bad_par);
    if (v.par == 2'b10) send_bit(~ones ^ v.bad_par);
    if (v.stop2) send_bit(1'b1);
    send_bit(~v.bad_stop);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pop();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0, 1:    return "R2 8-bit";
      2:       return "R3 7-bit";
      3, 4:    return "R4 even";
      5, 6:    return "R5 odd";
      default: return "R6 stop";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", rd_valid, 0);
    check("R1 count", count, 0);
    check("R1 overrun", overrun, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send_frame(VECS[i]);
      check(vec_req(i), {rd_valid, rd_data}, {1'b1, VECS[i].exp_data});
      check(vec_req(i), {rd_perr, rd_ferr}, {VECS[i].bad_par, VECS[i].bad_stop});
      pop();
      check("R8 empty after pop", count, 0);
    end

    // R7: low for 4 ticks only
    len8 = 1'b1; par = 2'b00; stop2 = 1'b0;
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    send_bit(1'b1);
    repeat (12) send_bit(1'b1);
    check("R7 glitch ignored", {rd_valid, count}, 9'd0);

    // R8/R9: fill beyond depth
    for (int i = 0; i <= DEPTH; i++)
      send_frame('{1'b1, 2'b00, 1'b0, i[7:0], 1'b0, 1'b0, i[7:0]});
    check("R8 full count", count, DEPTH);
    check("R9 overrun set", overrun, 1);
    repeat (5) @(negedge clk);
    check("R9 overrun sticky", overrun, 1);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
        if (!rd_valid || rd_data !== i[7:0]) bad++;
        pop();
      end
      check("R8 arrival order", bad, 0);
    end
    check("R8 drained", {rd_valid, count}, 9'd0);
    check("R9 overrun kept while draining", overrun, 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    check("R9 overrun cleared", overrun, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule